// File: doc/BRIEF.md
# SPI-to-NAND Bridge Controller

This block is an SPI slave that turns host SPI frames into cycles on a parallel 8-bit NAND flash bus. It also holds a configuration register whose bits drive the NAND chip enable, the command and address latch enables, a fan output and four LEDs. Every frame opens with a one-byte opcode received one bit per SCK clock. The opcode selects one of four operations: a multi-byte write, a configuration load, a read, or a fast read that waits through extra idle bytes before data flows.

The SPI pins are oversampled in the system clock domain. SCK, chip select and both data-in lines pass through the same synchronizer depth, so their timing relation is kept. Write data uses a double-width data phase: two bits arrive on each rising SCK edge, one on each data-in line. A written byte is committed to the NAND bus only when the byte after it has arrived, so the turnaround byte that ends a write frame never reaches the flash. For reads, the NAND read strobe for a byte is issued one byte time ahead. The byte is then ready when its top bit is placed on MISO after the falling SCK edge that closes the previous byte.

Top module: `spi_nand_bridge`

## Requirements
- R1: After reset the configuration register holds 0x8F, so chip enable is high (inactive), CLE, ALE and fan are low, and all four active-low LED outputs are high. The write and read strobes are high, the data bus is not driven and MISO is low.
- R2: Opcode 0x09 loads the next single-bit byte into the configuration register. Bit 7 drives nand_ce_n, bit 6 drives nand_cle, bit 5 drives nand_ale, bit 4 drives fan_en, and bits 3..0 drive led_n[3:0]. Any further bytes in that frame leave the register unchanged.
- R3: The opcode byte is taken one bit per rising SCK edge from spi_d0, most significant bit first. A bit-reversed opcode is therefore not recognised.
- R4: After opcode 0x08, each byte arrives two bits per rising SCK edge over four edges, most significant pair first. spi_d0 carries the higher bit of each pair and spi_d1 the lower bit. The bytes are written to the NAND bus in arrival order, each with one write strobe pulse.
- R5: In a write frame a byte is committed when the following byte has fully arrived. The last complete byte of the frame is a turnaround byte and is never written.
- R6: After opcode 0x0A there is one idle byte during which MISO is low. Each byte time after that shifts one NAND byte out on MISO, MSB first, with MISO changing after falling SCK edges.
- R7: After opcode 0x0B there are four idle bytes with MISO low before NAND data is shifted out in the same way as R6.
- R8: In a read frame, one read strobe pulse is issued at the first rising SCK edge of the last idle byte and of every data byte. A read frame with N data bytes therefore issues N+1 read strobes.
- R9: Raising chip select at any point ends the frame. Partially received bytes and uncommitted write bytes are discarded, and the next frame starts again with an opcode.
- R10: An unknown opcode makes the rest of the frame ignored: no strobes are issued and the configuration does not change.
- R11: The NAND data bus is driven only from one cycle before a write strobe falls to one cycle after it rises. The data stays stable for that whole window, and the write and read strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the SCK rate |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Host serial clock, idle low |
| spi_cs_n | input | 1 | Host chip select, active low |
| spi_d0 | input | 1 | Primary serial data in (single-bit data and high bit of pairs) |
| spi_d1 | input | 1 | Secondary serial data in (low bit of pairs) |
| spi_miso | output | 1 | Serial data out to the host |
| nand_dq_out | output | 8 | NAND data bus output value |
| nand_dq_oe | output | 1 | NAND data bus output enable |
| nand_dq_in | input | 8 | NAND data bus input value |
| nand_we_n | output | 1 | NAND write strobe, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| nand_ce_n | output | 1 | NAND chip enable, active low (configuration bit 7) |
| nand_cle | output | 1 | NAND command latch enable (configuration bit 6) |
| nand_ale | output | 1 | NAND address latch enable (configuration bit 5) |
| fan_en | output | 1 | Fan enable (configuration bit 4) |
| led_n | output | 4 | LED drives, active low (configuration bits 3..0) |

## Verification
The bench builds the bridge with a three-cycle write strobe and a two-cycle read strobe, so both strobe counters run a real count. It keeps the idle counts at one and four, which lets a single bench tell the two read opcodes apart by where data first appears. The SCK half period is eight system clocks. This leaves room for the synchronizer latency and for the read strobe that completes a full byte ahead of MISO. Aborted frames are cut both halfway through a configuration byte and inside the write data phase, which exposes the dropping of a pending write byte.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam logic [7:0] OPC_WRITE  = 8'h08;
  localparam logic [7:0] OPC_CONFIG = 8'h09;
  localparam logic [7:0] OPC_READ   = 8'h0A;
  localparam logic [7:0] OPC_FREAD  = 8'h0B;

  typedef enum logic [2:0] {
    FR_OPCODE, FR_WDATA, FR_CFG, FR_IDLE, FR_RDATA, FR_IGNORE
  } frame_st_t;

  typedef enum logic [2:0] {
    NS_IDLE, NS_WSETUP, NS_WLOW, NS_WHOLD, NS_RLOW
  } nand_st_t;
endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  input  logic cs_n_in,
  input  logic d0_in,
  input  logic d1_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_active,
  output logic cs_end,
  output logic d0_s,
  output logic d1_s
);
  localparam int LANES = 4;

  logic [LANES-1:0] raw;
  logic [LANES-1:0] synced;
  logic             sck_d;
  logic             cs_d;

  assign raw = {d1_in, d0_in, cs_n_in, sck_in};

  // Every lane sees the same depth so data keeps its relation to SCK.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= (g == 1) ? {STAGES{1'b1}} : {STAGES{1'b0}};
      else     sh <= {sh[STAGES-2:0], raw[g]};
    end
    assign synced[g] = sh[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= synced[0];
      cs_d  <= synced[1];
    end
  end

  assign sck_rise  = synced[0] & ~sck_d;
  assign sck_fall  = ~synced[0] & sck_d;
  assign cs_active = ~synced[1];
  assign cs_end    = synced[1] & ~cs_d;
  assign d0_s      = synced[2];
  assign d1_s      = synced[3];
endmodule

// File: rtl/bridge_frame.sv
module bridge_frame
  import bridge_pkg::*;
#(
  parameter int IDLE_RD   = 1,
  parameter int IDLE_FAST = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       cs_active,
  input  logic       cs_end,
  input  logic       d0,
  input  logic       d1,
  input  logic [7:0] rd_byte,
  output logic       wr_req,
  output logic       rd_req,
  output logic       cfg_load,
  output logic [7:0] evt_byte,
  output logic       miso
);
  localparam int IMAX = (IDLE_RD > IDLE_FAST) ? IDLE_RD : IDLE_FAST;
  localparam int IW   = $clog2(IMAX + 1);

  frame_st_t   st;
  logic [2:0]  bit_cnt;
  logic [7:0]  rx_sr;
  logic [7:0]  pend;
  logic        pend_v;
  logic [IW-1:0] idle_left;
  logic [7:0]  tx_sr;
  logic        tx_load;
  logic        wide;
  logic        last_bit;
  logic [7:0]  shifted;

  assign wide     = (st == FR_WDATA);
  assign last_bit = wide ? (bit_cnt == 3'd3) : (bit_cnt == 3'd7);
  assign shifted  = wide ? {rx_sr[5:0], d0, d1} : {rx_sr[6:0], d0};
  assign miso     = tx_sr[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= FR_OPCODE;
      bit_cnt   <= 3'd0;
      rx_sr     <= 8'h00;
      pend      <= 8'h00;
      pend_v    <= 1'b0;
      idle_left <= '0;
      tx_sr     <= 8'h00;
      tx_load   <= 1'b0;
      wr_req    <= 1'b0;
      rd_req    <= 1'b0;
      cfg_load  <= 1'b0;
      evt_byte  <= 8'h00;
    end else begin
      wr_req   <= 1'b0;
      rd_req   <= 1'b0;
      cfg_load <= 1'b0;
      if (cs_end) begin
        st        <= FR_OPCODE;
        bit_cnt   <= 3'd0;
        pend_v    <= 1'b0;
        idle_left <= '0;
        tx_sr     <= 8'h00;
        tx_load   <= 1'b0;
      end else if (cs_active) begin
        if (sck_rise && st != FR_IGNORE) begin
          rx_sr <= shifted;
          // Read strobe one byte time ahead of the byte it feeds.
          if (bit_cnt == 3'd0 &&
              ((st == FR_IDLE && idle_left == IW'(1)) || st == FR_RDATA))
            rd_req <= 1'b1;
          if (last_bit) begin
            bit_cnt <= 3'd0;
            unique case (st)
              FR_OPCODE: begin
                unique case (shifted)
                  OPC_WRITE:  st <= FR_WDATA;
                  OPC_CONFIG: st <= FR_CFG;
                  OPC_READ: begin
                    st        <= FR_IDLE;
                    idle_left <= IW'(IDLE_RD);
                  end
                  OPC_FREAD: begin
                    st        <= FR_IDLE;
                    idle_left <= IW'(IDLE_FAST);
                  end
                  default: st <= FR_IGNORE;
                endcase
              end
              FR_WDATA: begin
                if (pend_v) begin
                  wr_req   <= 1'b1;
                  evt_byte <= pend;
                end
                pend   <= shifted;
                pend_v <= 1'b1;
              end
              FR_CFG: begin
                cfg_load <= 1'b1;
                evt_byte <= shifted;
                st       <= FR_IGNORE;
              end
              FR_IDLE: begin
                idle_left <= idle_left - IW'(1);
                if (idle_left == IW'(1)) begin
                  st      <= FR_RDATA;
                  tx_load <= 1'b1;
                end
              end
              FR_RDATA: tx_load <= 1'b1;
              default: ;
            endcase
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
          end
        end
        if (sck_fall) begin
          if (tx_load) begin
            tx_sr   <= rd_byte;
            tx_load <= 1'b0;
          end else begin
            tx_sr <= {tx_sr[6:0], 1'b0};
          end
        end
      end
    end
  end

  a_r9_abort_to_opcode: assert property (@(posedge clk) disable iff (rst)
    cs_end |=> (st == FR_OPCODE && bit_cnt == 3'd0 && !pend_v));

  a_r10_ignore_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == FR_IGNORE) |=> (!wr_req && !rd_req && !cfg_load));

  a_r6_load_only_reading: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> (st == FR_RDATA));
endmodule

// File: rtl/bridge_nand_io.sv
module bridge_nand_io
  import bridge_pkg::*;
#(
  parameter int WE_LOW = 2,
  parameter int RE_LOW = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_req,
  input  logic [7:0] wr_byte,
  input  logic       rd_req,
  input  logic [7:0] dq_in,
  output logic [7:0] dq_out,
  output logic       dq_oe,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] rd_byte
);
  localparam int CMAX = (WE_LOW > RE_LOW) ? WE_LOW : RE_LOW;
  localparam int CW   = $clog2(CMAX + 1);

  nand_st_t      ns;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ns      <= NS_IDLE;
      cnt     <= '0;
      dq_out  <= 8'h00;
      dq_oe   <= 1'b0;
      we_n    <= 1'b1;
      re_n    <= 1'b1;
      rd_byte <= 8'h00;
    end else begin
      unique case (ns)
        NS_IDLE: begin
          if (wr_req) begin
            dq_out <= wr_byte;
            dq_oe  <= 1'b1;
            ns     <= NS_WSETUP;
          end else if (rd_req) begin
            re_n <= 1'b0;
            cnt  <= CW'(RE_LOW - 1);
            ns   <= NS_RLOW;
          end
        end
        NS_WSETUP: begin
          we_n <= 1'b0;
          cnt  <= CW'(WE_LOW - 1);
          ns   <= NS_WLOW;
        end
        NS_WLOW: begin
          if (cnt == '0) begin
            we_n <= 1'b1;
            ns   <= NS_WHOLD;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        NS_WHOLD: begin
          dq_oe <= 1'b0;
          ns    <= NS_IDLE;
        end
        NS_RLOW: begin
          if (cnt == '0) begin
            re_n    <= 1'b1;
            rd_byte <= dq_in;
            ns      <= NS_IDLE;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: ns <= NS_IDLE;
      endcase
    end
  end

  a_r11_no_strobe_overlap: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));

  a_r11_bus_under_we: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> dq_oe);

  a_r11_bus_stable: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

  a_r8_req_when_free: assert property (@(posedge clk) disable iff (rst)
    (wr_req || rd_req) |-> (ns == NS_IDLE));
endmodule

// File: rtl/spi_nand_bridge.sv
module spi_nand_bridge #(
  parameter int         SYNC_STAGES = 2,
  parameter int         WE_LOW_CYC  = 2,
  parameter int         RE_LOW_CYC  = 3,
  parameter int         IDLE_RD     = 1,
  parameter int         IDLE_FAST   = 4,
  parameter logic [7:0] CFG_INIT    = 8'h8F
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_d0,
  input  logic       spi_d1,
  output logic       spi_miso,
  output logic [7:0] nand_dq_out,
  output logic       nand_dq_oe,
  input  logic [7:0] nand_dq_in,
  output logic       nand_we_n,
  output logic       nand_re_n,
  output logic       nand_ce_n,
  output logic       nand_cle,
  output logic       nand_ale,
  output logic       fan_en,
  output logic [3:0] led_n
);
  logic       sck_rise, sck_fall, cs_active, cs_end, d0_s, d1_s;
  logic       wr_req, rd_req, cfg_load;
  logic [7:0] evt_byte, rd_byte;
  logic [7:0] cfg_q;

  bridge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .sck_in(spi_sck), .cs_n_in(spi_cs_n), .d0_in(spi_d0), .d1_in(spi_d1),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_active(cs_active), .cs_end(cs_end),
    .d0_s(d0_s), .d1_s(d1_s)
  );

  bridge_frame #(.IDLE_RD(IDLE_RD), .IDLE_FAST(IDLE_FAST)) u_frame (
    .clk(clk), .rst(rst),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_active(cs_active), .cs_end(cs_end),
    .d0(d0_s), .d1(d1_s),
    .rd_byte(rd_byte),
    .wr_req(wr_req), .rd_req(rd_req), .cfg_load(cfg_load),
    .evt_byte(evt_byte), .miso(spi_miso)
  );

  bridge_nand_io #(.WE_LOW(WE_LOW_CYC), .RE_LOW(RE_LOW_CYC)) u_nand (
    .clk(clk), .rst(rst),
    .wr_req(wr_req), .wr_byte(evt_byte), .rd_req(rd_req),
    .dq_in(nand_dq_in), .dq_out(nand_dq_out), .dq_oe(nand_dq_oe),
    .we_n(nand_we_n), .re_n(nand_re_n), .rd_byte(rd_byte)
  );

  always_ff @(posedge clk) begin
    if (rst)           cfg_q <= CFG_INIT;
    else if (cfg_load) cfg_q <= evt_byte;
  end

  assign nand_ce_n = cfg_q[7];
  assign nand_cle  = cfg_q[6];
  assign nand_ale  = cfg_q[5];
  assign fan_en    = cfg_q[4];
  assign led_n     = cfg_q[3:0];

  a_r2_cfg_changes_on_load: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(cfg_q));
endmodule

// File: tb/tb_spi_nand_bridge.sv
module tb_spi_nand_bridge;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, d0 = 1'b0, d1 = 1'b0;
  logic miso, dq_oe, we_n, re_n, ce_n, cle, ale, fan;
  logic [7:0] dq_out, dq_in;
  logic [3:0] led_n;

  spi_nand_bridge #(.WE_LOW_CYC(3), .RE_LOW_CYC(2)) dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_d0(d0), .spi_d1(d1), .spi_miso(miso),
    .nand_dq_out(dq_out), .nand_dq_oe(dq_oe), .nand_dq_in(dq_in),
    .nand_we_n(we_n), .nand_re_n(re_n), .nand_ce_n(ce_n),
    .nand_cle(cle), .nand_ale(ale), .fan_en(fan), .led_n(led_n)
  );

  logic [7:0] nmem [16];
  logic [7:0] wlog [16];
  int rptr = 0, re_pulses = 0, wcnt = 0;
  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  assign dq_in = re_n ? 8'h00 : nmem[rptr[3:0]];

  always @(posedge re_n) if (!rst) begin rptr++; re_pulses++; end
  always @(posedge we_n) if (!rst && dq_oe) begin wlog[wcnt[3:0]] = dq_out; wcnt++; end

  function automatic logic [7:0] cfg_view();
    return {ce_n, cle, ale, fan, led_n};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic frame_open(); cs_n = 1'b0; tick(HALF); endtask
  task automatic frame_close();
    tick(HALF); cs_n = 1'b1; d0 = 1'b0; d1 = 1'b0; tick(12);
  endtask

  task automatic bits1(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nb; i--) begin
      d0 = tx[i];
      tick(HALF);
      rx[i] = miso;
      sck = 1'b1; tick(HALF); sck = 1'b0;
    end
  endtask

  task automatic xfer1(input logic [7:0] tx, output logic [7:0] rx);
    bits1(tx, 8, rx);
  endtask

  task automatic pairs2(input logic [7:0] tx, input int np);
    for (int p = 3; p > 3 - np; p--) begin
      d0 = tx[2*p+1]; d1 = tx[2*p];
      tick(HALF);
      sck = 1'b1; tick(HALF); sck = 1'b0;
    end
  endtask

  task automatic t_reset();
    check("R1 config reset", cfg_view(), 8'h8F);
    check("R1 we_n", {7'd0, we_n}, 8'd1);
    check("R1 re_n", {7'd0, re_n}, 8'd1);
    check("R1 bus idle", {7'd0, dq_oe}, 8'd0);
    check("R1 miso", {7'd0, miso}, 8'd0);
  endtask

  task automatic t_config();
    logic [7:0] r;
    frame_open(); xfer1(8'h09, r); xfer1(8'h6A, r); xfer1(8'hFF, r); frame_close();
    check("R2 config load and trailing byte ignored", cfg_view(), 8'h6A);
    check("R2 no strobes", 8'(wcnt + re_pulses), 8'd0);
  endtask

  task automatic t_write();
    logic [7:0] r;
    wcnt = 0;
    frame_open(); xfer1(8'h08, r);
    pairs2(8'hA5, 4); pairs2(8'h3C, 4); pairs2(8'hE1, 4); pairs2(8'h00, 4);
    frame_close();
    check("R5 turnaround byte not written", 8'(wcnt), 8'd3);
    check("R4 byte0", wlog[0], 8'hA5);
    check("R4 byte1", wlog[1], 8'h3C);
    check("R4 byte2", wlog[2], 8'hE1);
    check("R11 bus released", {7'd0, dq_oe}, 8'd0);
  endtask

  task automatic t_read();
    logic [7:0] r;
    rptr = 0; re_pulses = 0;
    frame_open(); xfer1(8'h0A, r); xfer1(8'h00, r);
    check("R6 idle byte miso low", r, 8'h00);
    for (int k = 0; k < 3; k++) begin
      xfer1(8'h00, r);
      check($sformatf("R6 read byte %0d", k), r, nmem[k]);
    end
    frame_close();
    check("R8 read strobes N+1", 8'(re_pulses), 8'd4);
  endtask

  task automatic t_fast();
    logic [7:0] r;
    rptr = 0; re_pulses = 0;
    frame_open(); xfer1(8'h0B, r);
    for (int k = 0; k < 4; k++) begin
      xfer1(8'h00, r);
      check($sformatf("R7 idle byte %0d", k), r, 8'h00);
    end
    for (int k = 0; k < 2; k++) begin
      xfer1(8'h00, r);
      check($sformatf("R7 fast byte %0d", k), r, nmem[k]);
    end
    frame_close();
    check("R8 fast strobes N+1", 8'(re_pulses), 8'd3);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    frame_open(); xfer1(8'h09, r); bits1(8'hF0, 4, r); frame_close();
    check("R9 partial config dropped", cfg_view(), 8'h6A);
    wcnt = 0;
    frame_open(); xfer1(8'h08, r); pairs2(8'h11, 4); pairs2(8'h22, 4); pairs2(8'h33, 2);
    frame_close();
    check("R9 pending write dropped", 8'(wcnt), 8'd1);
    check("R9 committed write", wlog[0], 8'h11);
    frame_open(); xfer1(8'h09, r); xfer1(8'h3C, r); frame_close();
    check("R9 opcode after abort", cfg_view(), 8'h3C);
  endtask

  task automatic t_unknown();
    logic [7:0] r;
    wcnt = 0; re_pulses = 0;
    frame_open(); xfer1(8'h55, r); xfer1(8'h09, r); xfer1(8'h00, r); frame_close();
    check("R10 unknown opcode config", cfg_view(), 8'h3C);
    check("R10 unknown opcode strobes", 8'(wcnt + re_pulses), 8'd0);
    frame_open(); xfer1(8'h50, r); xfer1(8'h00, r); xfer1(8'h00, r); frame_close();
    check("R3 reversed opcode not a read", 8'(re_pulses), 8'd0);
    check("R3 reversed opcode miso", r, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) nmem[i] = 8'(8'h31 + i * 8'h4B);
    tick(5); rst = 1'b0; tick(5);
    t_reset();
    t_config();
    t_write();
    t_read();
    t_fast();
    t_abort();
    t_unknown();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule